// File: doc/BRIEF.md
# Sync Activity Detector and Source Selector

This block watches three raw timing inputs: a horizontal sync, a sync-on-green composite, and a vertical sync. It decides which of them are alive, measures the polarity of each, and picks one horizontal source and one vertical source for the downstream timing logic. Both picked syncs leave the block active-high, whatever their polarity on the wire.

A level-duration filter recovers a vertical pulse from the composite sync-on-green signal. It counts reference-clock cycles spent at a level and follows the input only when that level outlasts a programmable 8-bit threshold. Short horizontal pulses are therefore dropped, and only the long vertical interval gets through.

Source choice follows a fixed table built from the activity flags and a priority bit per axis. Setting an override bit for an axis pins that axis's choice to its priority bit. All logic runs on the single reference clock, and the raw inputs are sampled once on entry.

Top module: `sync_src_sel`

## Requirements
- R1: While reset is asserted, every output is 0.
- R2: A detect flag (`hs_det`, `sog_det`, `vs_det`) becomes 1 when two edges of its input fall within WIN reference cycles of each other. It returns to 0 once WIN-1 cycles pass with no edge. An input held high or held low reads 0.
- R3: With `h_ovr` = 0, `h_src_sog` is 1 when only sync-on-green is active and 0 when only the horizontal sync is active. When both are active, or neither is, it equals `h_prio`.
- R4: With `h_ovr` = 1, `h_src_sog` equals `h_prio` on the following cycle, regardless of activity.
- R5: With `v_ovr` = 0, `v_src_sep` is 0 when only the vertical sync is active and 1 when only sync-on-green is active. When both are active, or neither is, it equals `v_prio`.
- R6: With `v_ovr` = 1, `v_src_sep` equals `v_prio` on the following cycle.
- R7: `hs_pol` is 1 (positive) when the horizontal input spends fewer cycles high than low. `vs_pol` is 1 (active low) when the vertical input spends fewer cycles low than high. Time spent at each level is tracked by a saturating up/down balance.
- R8: `hs_out` shows the horizontal source picked by `h_src_sog`, 2 cycles after the input. It is inverted when that source's measured polarity is negative.
- R9: When `v_src_sep` = 0, `vs_out` shows the vertical sync input 2 cycles later. It is inverted when `vs_pol` = 1.
- R10: The separator changes its output only after its input has differed from that output for more than `sep_thr` consecutive cycles. When `v_src_sep` = 1, `vs_out` carries this output, normalised with the sync-on-green polarity. Composite pulses no longer than the threshold never reach `vs_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Raw horizontal sync |
| sog_in | input | 1 | Raw sync-on-green composite sync |
| vs_in | input | 1 | Raw vertical sync |
| sep_thr | input | 8 | Separator level-duration threshold in reference cycles |
| h_prio | input | 1 | Horizontal priority/forced value (1 = sync-on-green) |
| h_ovr | input | 1 | Forces `h_src_sog` to `h_prio` |
| v_prio | input | 1 | Vertical priority/forced value (1 = separator) |
| v_ovr | input | 1 | Forces `v_src_sep` to `v_prio` |
| hs_out | output | 1 | Selected horizontal sync, active-high |
| vs_out | output | 1 | Selected vertical sync, active-high |
| h_src_sog | output | 1 | 1 = sync-on-green drives `hs_out` |
| v_src_sep | output | 1 | 1 = separator drives `vs_out` |
| hs_det | output | 1 | Horizontal sync activity |
| sog_det | output | 1 | Sync-on-green activity |
| vs_det | output | 1 | Vertical sync activity |
| hs_pol | output | 1 | Horizontal polarity, 1 = positive |
| vs_pol | output | 1 | Vertical polarity, 1 = active low |

## Verification
The pass-through paths of `hs_out` and `vs_out` lag the input by exactly two reference cycles: one sampling register and one output register. The bench keeps a two-deep history of each input and compares against it at every falling edge. Detection, polarity and source flags settle over up to WIN cycles plus the time the balance counter needs to swing, so each stimulus vector is held for 2500 cycles before those flags are read. The separator needs more than `sep_thr` cycles to follow a level, plus two registers. Its checks therefore sample only phase ranges of the test frame that lie well inside or well outside the widened vertical pulse.

// File: rtl/sync_src_pkg.sv
package sync_src_pkg;

    typedef struct packed {
        logic [2:0] raw;     // sampled {vs, sog, hs}
        logic       h_sog;
        logic       v_sep;
        logic       hs_out;
        logic       vs_out;
        logic       hs_det;
        logic       sog_det;
        logic       vs_det;
        logic       hs_pol;
        logic       vs_pol;
    } top_state_t;

    // Source choice per axis: 0 picks the primary input, 1 picks the
    // sync-on-green derived path.
    function automatic logic pick_src(input logic ovr, input logic prio,
                                      input logic prim_act, input logic sog_act);
        logic r;
        if (ovr)                       r = prio;
        else if (prim_act && !sog_act) r = 1'b0;
        else if (!prim_act && sog_act) r = 1'b1;
        else                           r = prio;
        return r;
    endfunction

endpackage

// File: rtl/sync_act_det.sv
module sync_act_det #(
    parameter int WIN       = 1024,
    parameter int BAL_W     = 10,
    parameter bit LOW_SENSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic act,
    output logic pol
);
    localparam int TW = $clog2(WIN);
    localparam logic [TW-1:0]    TMO  = TW'(WIN - 1);
    localparam logic [BAL_W-1:0] BMAX = BAL_W'((2 ** (BAL_W - 1)) - 1);
    localparam logic [BAL_W-1:0] BMIN = BAL_W'(-((2 ** (BAL_W - 1)) - 1));

    typedef struct packed {
        logic             last;
        logic             seen;
        logic             act;
        logic [TW-1:0]    tmr;
        logic [BAL_W-1:0] bal;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        logic edge_seen;
        logic tmo;
        st_d      = st_q;
        st_d.last = sig;
        edge_seen = sig != st_q.last;
        tmo       = st_q.tmr == TMO;
        if (edge_seen) begin
            st_d.tmr  = '0;
            st_d.seen = 1'b1;
            if (st_q.seen && !tmo) st_d.act = 1'b1;
        end else if (tmo) begin
            st_d.seen = 1'b0;
            st_d.act  = 1'b0;
        end else begin
            st_d.tmr = st_q.tmr + 1'b1;
        end
        if (sig && st_q.bal != BMAX)       st_d.bal = st_q.bal + 1'b1;
        else if (!sig && st_q.bal != BMIN) st_d.bal = st_q.bal - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act = st_q.act;

    generate
        if (LOW_SENSE) begin : g_low
            assign pol = $signed(st_q.bal) > 0;
        end else begin : g_high
            assign pol = $signed(st_q.bal) < 0;
        end
    endgenerate

endmodule

// File: rtl/sync_separator.sv
module sync_separator #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig,
    input  logic [THR_W-1:0] thr,
    output logic             sep_out
);
    localparam int CW = THR_W + 1;

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } sep_t;

    sep_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sig == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt > {1'b0, thr}) begin
            st_d.lvl = sig;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sep_out = st_q.lvl;

endmodule

// File: rtl/sync_src_sel.sv
module sync_src_sel
    import sync_src_pkg::*;
#(
    parameter int WIN   = 1024,
    parameter int BAL_W = 10,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_in,
    input  logic             sog_in,
    input  logic             vs_in,
    input  logic [THR_W-1:0] sep_thr,
    input  logic             h_prio,
    input  logic             h_ovr,
    input  logic             v_prio,
    input  logic             v_ovr,
    output logic             hs_out,
    output logic             vs_out,
    output logic             h_src_sog,
    output logic             v_src_sep,
    output logic             hs_det,
    output logic             sog_det,
    output logic             vs_det,
    output logic             hs_pol,
    output logic             vs_pol
);
    localparam int NCH    = 3;
    localparam int CH_HS  = 0;
    localparam int CH_SOG = 1;
    localparam int CH_VS  = 2;

    top_state_t st_d, st_q;
    logic [NCH-1:0] act;
    logic [NCH-1:0] pol;
    logic           sep_o;

    // Horizontal and composite channels report "high is short"; the
    // vertical channel reports "low is short".
    generate
        for (genvar g = 0; g < NCH; g++) begin : g_det
            sync_act_det #(
                .WIN      (WIN),
                .BAL_W    (BAL_W),
                .LOW_SENSE(g == CH_VS)
            ) u_det (
                .clk  (clk),
                .rst_n(rst_n),
                .sig  (st_q.raw[g]),
                .act  (act[g]),
                .pol  (pol[g])
            );
        end
    endgenerate

    sync_separator #(.THR_W(THR_W)) u_sep (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig    (st_q.raw[CH_SOG]),
        .thr    (sep_thr),
        .sep_out(sep_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.raw     = {vs_in, sog_in, hs_in};
        st_d.h_sog   = pick_src(h_ovr, h_prio, act[CH_HS], act[CH_SOG]);
        st_d.v_sep   = pick_src(v_ovr, v_prio, act[CH_VS], act[CH_SOG]);
        st_d.hs_out  = st_d.h_sog ? (st_q.raw[CH_SOG] ^ ~pol[CH_SOG])
                                  : (st_q.raw[CH_HS]  ^ ~pol[CH_HS]);
        st_d.vs_out  = st_d.v_sep ? (sep_o ^ ~pol[CH_SOG])
                                  : (st_q.raw[CH_VS] ^ pol[CH_VS]);
        st_d.hs_det  = act[CH_HS];
        st_d.sog_det = act[CH_SOG];
        st_d.vs_det  = act[CH_VS];
        st_d.hs_pol  = pol[CH_HS];
        st_d.vs_pol  = pol[CH_VS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_out    = st_q.hs_out;
    assign vs_out    = st_q.vs_out;
    assign h_src_sog = st_q.h_sog;
    assign v_src_sep = st_q.v_sep;
    assign hs_det    = st_q.hs_det;
    assign sog_det   = st_q.sog_det;
    assign vs_det    = st_q.vs_det;
    assign hs_pol    = st_q.hs_pol;
    assign vs_pol    = st_q.vs_pol;

endmodule

// File: rtl/sync_src_sel_chk.sv
module sync_src_sel_chk (
    input logic clk,
    input logic rst_n,
    input logic hs_in,
    input logic h_prio,
    input logic h_ovr,
    input logic v_prio,
    input logic v_ovr,
    input logic hs_out,
    input logic h_src_sog,
    input logic v_src_sep,
    input logic hs_det,
    input logic sog_det,
    input logic vs_det,
    input logic hs_pol
);
    // R4
    h_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_ovr |=> (h_src_sog == $past(h_prio)));

    // R6
    v_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_ovr |=> (v_src_sep == $past(v_prio)));

    // R3
    h_sog_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(h_ovr) && sog_det && !hs_det) |-> h_src_sog);

    // R3
    h_hs_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(h_ovr) && hs_det && !sog_det) |-> !h_src_sog);

    // R5
    v_vs_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(v_ovr) && vs_det && !sog_det) |-> !v_src_sep);

    // R5
    v_sog_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(v_ovr) && !vs_det && sog_det) |-> v_src_sep);

    // R8
    hs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_src_sog && hs_pol) |-> (hs_out == $past(hs_in, 2)));

endmodule

bind sync_src_sel sync_src_sel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_in    (hs_in),
    .h_prio   (h_prio),
    .h_ovr    (h_ovr),
    .v_prio   (v_prio),
    .v_ovr    (v_ovr),
    .hs_out   (hs_out),
    .h_src_sog(h_src_sog),
    .v_src_sep(v_src_sep),
    .hs_det   (hs_det),
    .sog_det  (sog_det),
    .vs_det   (vs_det),
    .hs_pol   (hs_pol)
);

// File: tb/sync_src_sel_bench.sv
module sync_src_sel_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_in = 1'b0, sog_in = 1'b0, vs_in = 1'b0;
    logic [7:0] sep_thr = 8'h20;
    logic h_prio = 1'b0, h_ovr = 1'b0, v_prio = 1'b0, v_ovr = 1'b0;
    logic hs_out, vs_out, h_src_sog, v_src_sep;
    logic hs_det, sog_det, vs_det, hs_pol, vs_pol;

    int checks = 0;
    int errors = 0;

    // stimulus modes: 0 held low, 1 positive pulses, 2 negative pulses, 3 held high
    logic [1:0] hm = 2'd0, sm = 2'd0, vm = 2'd0;
    logic       vert_en = 1'b0;
    int         ph = 0;
    logic [1:0] h_hist = '0, s_hist = '0, v_hist = '0;

    always #2.5 clk = ~clk;

    sync_src_sel u_sync_src_sel (
        .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .sog_in(sog_in), .vs_in(vs_in),
        .sep_thr(sep_thr), .h_prio(h_prio), .h_ovr(h_ovr), .v_prio(v_prio),
        .v_ovr(v_ovr), .hs_out(hs_out), .vs_out(vs_out), .h_src_sog(h_src_sog),
        .v_src_sep(v_src_sep), .hs_det(hs_det), .sog_det(sog_det),
        .vs_det(vs_det), .hs_pol(hs_pol), .vs_pol(vs_pol)
    );

    function automatic logic gen(input logic [1:0] m, input int pos, input int pw);
        case (m)
            2'd0:    return 1'b0;
            2'd1:    return pos < pw;
            2'd2:    return !(pos < pw);
            default: return 1'b1;
        endcase
    endfunction

    always @(negedge clk) begin
        ph <= ph + 1;
        hs_in <= gen(hm, (ph + 1) % 64, 4);
        vs_in <= gen(vm, (ph + 1) % 200, 6);
        if (vert_en && ((ph + 1) % 1024) < 192) sog_in <= (sm == 2'd2) ? 1'b0 : 1'b1;
        else sog_in <= gen(sm, (ph + 1) % 64, 4);
    end

    always @(posedge clk) begin
        h_hist <= {h_hist[0], hs_in};
        s_hist <= {s_hist[0], sog_in};
        v_hist <= {v_hist[0], vs_in};
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // {hm, sm, vm, h_prio, h_ovr, v_prio, v_ovr, exp_h_src_sog, exp_v_src_sep}
    localparam logic [11:0] VEC [8] = '{
        {2'd1, 2'd0, 2'd1, 4'b0000, 2'b00},
        {2'd0, 2'd2, 2'd0, 4'b0000, 2'b11},
        {2'd1, 2'd2, 2'd0, 4'b0000, 2'b01},
        {2'd1, 2'd2, 2'd2, 4'b1010, 2'b11},
        {2'd2, 2'd0, 2'd0, 4'b1100, 2'b10},
        {2'd0, 2'd2, 2'd1, 4'b0111, 2'b01},
        {2'd3, 2'd0, 2'd0, 4'b1000, 2'b10},
        {2'd2, 2'd1, 2'd2, 4'b1000, 2'b10}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({hs_out, vs_out, h_src_sog, v_src_sep, hs_det, sog_det, vs_det,
               hs_pol, vs_pol} == 9'd0, "R1",
              {hs_out, vs_out, h_src_sog, v_src_sep, hs_det, sog_det, vs_det, hs_pol, vs_pol}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            logic [11:0] v;
            logic [1:0]  selm;
            int          bad_h, bad_v;
            v = VEC[i];
            @(negedge clk);
            {hm, sm, vm} = v[11:6];
            {h_prio, h_ovr, v_prio, v_ovr} = v[5:2];
            repeat (2500) @(negedge clk);
            // R2 activity
            check(hs_det == (hm == 2'd1 || hm == 2'd2), "R2 hs_det", hs_det, (hm == 2'd1 || hm == 2'd2));
            check(sog_det == (sm == 2'd1 || sm == 2'd2), "R2 sog_det", sog_det, (sm == 2'd1 || sm == 2'd2));
            check(vs_det == (vm == 2'd1 || vm == 2'd2), "R2 vs_det", vs_det, (vm == 2'd1 || vm == 2'd2));
            // R3 R4 horizontal choice, R5 R6 vertical choice
            check(h_src_sog == v[1], "R3/R4 h_src_sog", h_src_sog, v[1]);
            check(v_src_sep == v[0], "R5/R6 v_src_sep", v_src_sep, v[0]);
            // R7 polarity
            if (hm == 2'd1 || hm == 2'd2) check(hs_pol == (hm == 2'd1), "R7 hs_pol", hs_pol, hm == 2'd1);
            if (vm == 2'd1 || vm == 2'd2) check(vs_pol == (vm == 2'd2), "R7 vs_pol", vs_pol, vm == 2'd2);
            // R8 / R9 pass-through, 2-cycle latency, normalised
            selm  = v[1] ? sm : hm;
            bad_h = 0;
            bad_v = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (hs_out != ((v[1] ? s_hist[1] : h_hist[1]) ^ (selm == 2'd2))) bad_h++;
                if (vs_out != (v_hist[1] ^ (vm == 2'd2))) bad_v++;
            end
            if (selm == 2'd1 || selm == 2'd2) check(bad_h == 0, "R8 hs_out mismatches", bad_h, 0);
            if (!v[0] && (vm == 2'd1 || vm == 2'd2)) check(bad_v == 0, "R9 vs_out mismatches", bad_v, 0);
        end

        // R10: separator recovers vertical interval from composite
        begin
            int bad_in, bad_out, ones;
            @(negedge clk);
            hm = 2'd0; vm = 2'd0; sm = 2'd2; vert_en = 1'b1;
            h_ovr = 1'b0; v_ovr = 1'b1; v_prio = 1'b1;
            sep_thr = 8'h20;
            repeat (3000) @(negedge clk);
            check(v_src_sep == 1'b1, "R6 forced separator", v_src_sep, 1);
            while ((ph % 1024) != 0) @(negedge clk);
            bad_in = 0; bad_out = 0;
            for (int k = 0; k < 1024; k++) begin
                int p;
                p = ph % 1024;
                if (p >= 80 && p <= 180 && vs_out != 1'b1) bad_in++;
                if (p >= 320 && p <= 1000 && vs_out != 1'b0) bad_out++;
                @(negedge clk);
            end
            check(bad_in == 0, "R10 vertical pulse passed", bad_in, 0);
            check(bad_out == 0, "R10 line pulses filtered", bad_out, 0);

            // R10: threshold longer than the vertical interval blocks it
            sep_thr = 8'hFF;
            repeat (2048) @(negedge clk);
            ones = 0;
            for (int k = 0; k < 1024; k++) begin
                if (vs_out) ones++;
                @(negedge clk);
            end
            check(ones == 0, "R10 long threshold", ones, 0);
        end

        // R2: held high input clears detection
        @(negedge clk);
        vert_en = 1'b0; sm = 2'd3;
        repeat (1200) @(negedge clk);
        check(sog_det == 1'b0, "R2 held high", sog_det, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule